// File: doc/BRIEF.md
# PHY Reset and Receive-PLL Lock Sequencer

This block brings a serial PHY out of reset and confirms that the receive PLL has locked. It does this entirely through an indirect register access master that sits beside it. The sequencer issues three kinds of command to that master: an address capture, a data write and a data read. It waits for each command to finish or time out. It turns the PHY reference clock enable on and lets the clock settle. Next it selects the PHY clock-reset register and writes a value with the reset bit set. It then enters a bounded polling loop. Each attempt waits for a gap, selects the lane output status register, reads it and tests the receive-PLL-state bit.

A single start pulse launches the whole sequence. While the sequence runs, busy is high. At the end, done pulses for one cycle and a two-bit result code says whether the sequence succeeded, the register master timed out, or the PLL never locked within the allowed number of attempts. All delays are cycle counts given as parameters, so a short configuration can be used for verification.

Top module: `phy_lock_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, clk_en_o and cmd_valid_o are 0 and err_code_o is 0 (none).
- R2: A start_i pulse while idle sets busy_o and clk_en_o on the next cycle and clears err_code_o to 0. For the next SETTLE_CYC cycles no command is issued, and the first command becomes valid in the cycle after that.
- R3: The reset step issues an address command (cmd_op_o = 0) with data 0x7F3F, and then a write command (cmd_op_o = 1) with data 0x0001, so bit 0 is set.
- R4: Each poll attempt follows GAP_CYC cycles with no command. It then issues an address command with data 0x2003 and a read command (cmd_op_o = 2) with data 0x0000. With a master that answers each command after RESP cycles, a run that ends on its n-th command ends after SETTLE_CYC + n*(RESP+1) + GAP_CYC*(number of polls begun) cycles.
- R5: Only bit 1 of the read data decides lock, and the other bits have no effect. When bit 1 is set on any attempt, the sequence ends with err_code_o = 0, and clk_en_o stays 1.
- R6: When MAX_TRIES reads in a row have bit 1 clear, the sequence ends with err_code_o = 2 (lock timeout) and clk_en_o = 0. No further attempt is made.
- R7: A cmd_timeout_i on any command ends the sequence at once with err_code_o = 1 (handshake timeout) and clk_en_o = 0, and no further command is issued. A timeout wins over a cmd_done_i in the same cycle.
- R8: While cmd_valid_o is high and neither cmd_done_i nor cmd_timeout_i is high, the command stays valid on the next cycle with cmd_op_o and cmd_data_o unchanged.
- R9: done_o is a one-cycle pulse in the cycle that busy_o falls. err_code_o keeps its value after done until the next accepted start, and err_o is 1 exactly when err_code_o is not 0.
- R10: A start_i pulse while busy_o is high has no effect on the command stream or on the timing of the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Result is an error |
| err_code_o | output | 2 | 0 none, 1 handshake timeout, 2 lock timeout |
| clk_en_o | output | 1 | PHY reference clock enable |
| cmd_valid_o | output | 1 | Command to the register master is pending |
| cmd_op_o | output | 2 | 0 address, 1 write, 2 read |
| cmd_data_o | output | 16 | Register address or write data |
| cmd_done_i | input | 1 | Master finished the pending command |
| cmd_timeout_i | input | 1 | Master gave up on the pending command |
| cmd_rdata_i | input | 16 | Read data, valid with cmd_done_i on a read |

## Verification
The bench aims at the edges of the retry loop. It checks lock on the first attempt, on a middle attempt and on the very last allowed attempt, and it checks a run where lock never comes. An off-by-one attempt counter would report a lock timeout where the run should succeed, or would issue an extra poll pair. Read data with every bit except the lock bit set catches a design that tests the wrong bit. Timeouts are injected on the first command, on a later read, and together with a done on the same cycle, which shows whether the design keeps issuing commands or lets a done override the failure. Exact end-cycle counts expose missing or extra settle and gap cycles. A start pulse during a run shows whether a busy sequencer restarts.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam int PHY_DW = 16;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } phy_op_e;

    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_HANDSHAKE = 2'd1,
        ERR_LOCK      = 2'd2
    } seq_err_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETTLE,
        S_RST_ADDR,
        S_RST_WR,
        S_GAP,
        S_POLL_ADDR,
        S_POLL_RD
    } seq_state_e;

    typedef struct packed {
        logic              valid;
        phy_op_e           op;
        logic [PHY_DW-1:0] data;
    } phy_cmd_t;

    // Command presented to the register master for a given sequencer state.
    function automatic phy_cmd_t cmd_for_state(
        input seq_state_e        st,
        input logic [PHY_DW-1:0] rst_reg,
        input logic [PHY_DW-1:0] rst_val,
        input logic [PHY_DW-1:0] lane_reg
    );
        phy_cmd_t c;
        c = '{valid: 1'b0, op: OP_ADDR, data: '0};
        unique case (st)
            S_RST_ADDR:  c = '{valid: 1'b1, op: OP_ADDR,  data: rst_reg};
            S_RST_WR:    c = '{valid: 1'b1, op: OP_WRITE, data: rst_val};
            S_POLL_ADDR: c = '{valid: 1'b1, op: OP_ADDR,  data: lane_reg};
            S_POLL_RD:   c = '{valid: 1'b1, op: OP_READ,  data: '0};
            default:     c = '{valid: 1'b0, op: OP_ADDR,  data: '0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    assign expire_o = run_i && (cnt_q == limit_i - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run_i || expire_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/phy_seq_tries.sv
module phy_seq_tries #(
    parameter int MAX_TRIES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int TW = $clog2(MAX_TRIES + 1);

    logic [TW-1:0] cnt_q;

    // High while the attempt in flight is the final one allowed.
    assign last_o = (cnt_q == TW'(MAX_TRIES - 1));

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + TW'(1);
        end
    end
endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
    import phy_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       cmd_done_i,
    input  logic       cmd_timeout_i,
    input  logic       lock_bit_i,
    input  logic       tmr_expire_i,
    input  logic       tries_last_i,
    output seq_state_e state_o,
    output logic       tmr_run_o,
    output logic       tmr_long_o,
    output logic       tries_clr_o,
    output logic       tries_inc_o,
    output logic       done_o,
    output seq_err_e   err_code_o,
    output logic       clk_en_o
);
    seq_state_e state_q;
    logic       done_q;
    seq_err_e   err_q;
    logic       clk_en_q;
    logic       accept;
    logic       resp_ok;

    assign accept      = (state_q == S_IDLE) && start_i;
    assign resp_ok     = cmd_done_i && !cmd_timeout_i;
    assign tmr_run_o   = (state_q == S_SETTLE) || (state_q == S_GAP);
    assign tmr_long_o  = (state_q == S_SETTLE);
    assign tries_clr_o = accept;
    assign tries_inc_o = (state_q == S_POLL_RD) && resp_ok && !lock_bit_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            done_q   <= 1'b0;
            err_q    <= ERR_NONE;
            clk_en_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        state_q  <= S_SETTLE;
                        err_q    <= ERR_NONE;
                        clk_en_q <= 1'b1;
                    end
                end
                S_SETTLE: begin
                    if (tmr_expire_i) state_q <= S_RST_ADDR;
                end
                S_GAP: begin
                    if (tmr_expire_i) state_q <= S_POLL_ADDR;
                end
                S_RST_ADDR, S_RST_WR, S_POLL_ADDR, S_POLL_RD: begin
                    if (cmd_timeout_i) begin
                        state_q  <= S_IDLE;
                        done_q   <= 1'b1;
                        err_q    <= ERR_HANDSHAKE;
                        clk_en_q <= 1'b0;
                    end else if (cmd_done_i) begin
                        if (state_q == S_RST_ADDR) begin
                            state_q <= S_RST_WR;
                        end else if (state_q == S_RST_WR) begin
                            state_q <= S_GAP;
                        end else if (state_q == S_POLL_ADDR) begin
                            state_q <= S_POLL_RD;
                        end else if (lock_bit_i) begin
                            state_q <= S_IDLE;
                            done_q  <= 1'b1;
                            err_q   <= ERR_NONE;
                        end else if (tries_last_i) begin
                            state_q  <= S_IDLE;
                            done_q   <= 1'b1;
                            err_q    <= ERR_LOCK;
                            clk_en_q <= 1'b0;
                        end else begin
                            state_q <= S_GAP;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign state_o    = state_q;
    assign done_o     = done_q;
    assign err_code_o = err_q;
    assign clk_en_o   = clk_en_q;
endmodule

// File: rtl/phy_lock_seq.sv
module phy_lock_seq
    import phy_seq_pkg::*;
#(
    parameter int          SETTLE_CYC = 25000,
    parameter int          GAP_CYC    = 25000,
    parameter int          MAX_TRIES  = 10,
    parameter logic [15:0] RST_REG    = 16'h7F3F,
    parameter int          RST_BIT    = 0,
    parameter logic [15:0] LANE_REG   = 16'h2003,
    parameter int          LOCK_BIT   = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o,
    output logic [1:0]  err_code_o,
    output logic        clk_en_o,
    output logic        cmd_valid_o,
    output logic [1:0]  cmd_op_o,
    output logic [15:0] cmd_data_o,
    input  logic        cmd_done_i,
    input  logic        cmd_timeout_i,
    input  logic [15:0] cmd_rdata_i
);
    localparam int          WAIT_MAX = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
    localparam int          CNT_W    = $clog2(WAIT_MAX + 1);
    localparam logic [15:0] RST_VAL  = 16'(1) << RST_BIT;

    seq_state_e       state;
    seq_err_e         err_code;
    phy_cmd_t         cmd;
    logic             tmr_run;
    logic             tmr_long;
    logic             tmr_expire;
    logic [CNT_W-1:0] tmr_limit;
    logic             tries_clr;
    logic             tries_inc;
    logic             tries_last;

    assign tmr_limit = tmr_long ? CNT_W'(SETTLE_CYC) : CNT_W'(GAP_CYC);

    phy_seq_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .cmd_done_i   (cmd_done_i),
        .cmd_timeout_i(cmd_timeout_i),
        .lock_bit_i   (cmd_rdata_i[LOCK_BIT]),
        .tmr_expire_i (tmr_expire),
        .tries_last_i (tries_last),
        .state_o      (state),
        .tmr_run_o    (tmr_run),
        .tmr_long_o   (tmr_long),
        .tries_clr_o  (tries_clr),
        .tries_inc_o  (tries_inc),
        .done_o       (done_o),
        .err_code_o   (err_code),
        .clk_en_o     (clk_en_o)
    );

    phy_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run_i   (tmr_run),
        .limit_i (tmr_limit),
        .expire_o(tmr_expire)
    );

    phy_seq_tries #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk   (clk),
        .rst   (rst),
        .clr_i (tries_clr),
        .inc_i (tries_inc),
        .last_o(tries_last)
    );

    assign cmd         = cmd_for_state(state, RST_REG, RST_VAL, LANE_REG);
    assign cmd_valid_o = cmd.valid;
    assign cmd_op_o    = cmd.op;
    assign cmd_data_o  = cmd.data;
    assign busy_o      = (state != S_IDLE);
    assign err_code_o  = err_code;
    assign err_o       = (err_code != ERR_NONE);
endmodule

// File: rtl/phy_lock_seq_chk.sv
module phy_lock_seq_chk #(
    parameter int MAX_TRIES = 10
) (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        clk_en_o,
    input logic        cmd_valid_o,
    input logic [1:0]  cmd_op_o,
    input logic [15:0] cmd_data_o,
    input logic        cmd_done_i,
    input logic        cmd_timeout_i
);
    logic [15:0] reads_q;

    always_ff @(posedge clk) begin
        if (rst || (start_i && !busy_o)) begin
            reads_q <= '0;
        end else if (cmd_valid_o && cmd_op_o == 2'd2 && cmd_done_i && !cmd_timeout_i) begin
            reads_q <= reads_q + 16'd1;
        end
    end

    assert_start_takes_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && clk_en_o && !cmd_valid_o));

    assert_cmd_needs_clk_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> (busy_o && clk_en_o));

    assert_read_bound_R6: assert property (@(posedge clk) disable iff (rst)
        reads_q <= 16'(MAX_TRIES));

    assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && !cmd_done_i && !cmd_timeout_i) |=>
            (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_data_o)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_busy_fall_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    assert_busy_start_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !cmd_done_i && !cmd_timeout_i) |=> busy_o);
endmodule

bind phy_lock_seq phy_lock_seq_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .clk_en_o     (clk_en_o),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_op_o     (cmd_op_o),
    .cmd_data_o   (cmd_data_o),
    .cmd_done_i   (cmd_done_i),
    .cmd_timeout_i(cmd_timeout_i)
);

// File: tb/tb_phy_lock_seq.sv
module tb_phy_lock_seq;
    localparam int S    = 6;
    localparam int G    = 4;
    localparam int MAXT = 4;
    localparam int RESP = 1;
    localparam int NEVER = 1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        busy_o, done_o, err_o, clk_en_o, cmd_valid_o;
    logic [1:0]  err_code_o, cmd_op_o;
    logic [15:0] cmd_data_o;
    logic        cmd_done_i = 1'b0;
    logic        cmd_timeout_i = 1'b0;
    logic [15:0] cmd_rdata_i = 16'h0000;

    int checks = 0;
    int fails  = 0;
    int gcyc   = 0;

    // responder configuration and log
    int          lock_after = NEVER;
    int          to_idx     = -1;
    bit          to_with_done = 1'b0;
    int          n_cmd = 0;
    int          n_read = 0;
    int          wcnt = 0;
    logic [1:0]  log_op [0:63];
    logic [15:0] log_dat[0:63];

    always #2 clk = ~clk;

    phy_lock_seq #(
        .SETTLE_CYC(S), .GAP_CYC(G), .MAX_TRIES(MAXT)
    ) dut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o),
        .clk_en_o(clk_en_o), .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
        .cmd_data_o(cmd_data_o), .cmd_done_i(cmd_done_i),
        .cmd_timeout_i(cmd_timeout_i), .cmd_rdata_i(cmd_rdata_i)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
        end
    endtask

    function automatic int exp_cycles(input int ncmd);
        int polls;
        polls = (ncmd > 2) ? (ncmd - 1) / 2 : 0;
        return S + (RESP + 1) * ncmd + G * polls + 1;
    endfunction

    // Register master model: answers each command RESP cycles after it appears.
    initial begin
        forever begin
            @(negedge clk);
            cmd_done_i    = 1'b0;
            cmd_timeout_i = 1'b0;
            if (cmd_valid_o) begin
                if (wcnt < RESP) begin
                    wcnt++;
                end else begin
                    if (n_cmd < 64) begin
                        log_op[n_cmd]  = cmd_op_o;
                        log_dat[n_cmd] = cmd_data_o;
                    end
                    if (n_cmd == to_idx) begin
                        cmd_timeout_i = 1'b1;
                        cmd_done_i    = to_with_done;
                    end else begin
                        cmd_done_i = 1'b1;
                    end
                    if (cmd_op_o == 2'd2) begin
                        cmd_rdata_i = (n_read >= lock_after) ? 16'h0002 : 16'hFFFD;
                        n_read++;
                    end
                    n_cmd++;
                    wcnt = 0;
                end
            end else begin
                wcnt = 0;
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            gcyc++;
            if (gcyc > 100000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", gcyc);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    // One complete run; checks result, command stream and end cycle.
    task automatic run_seq(input string req, input int lk, input int tidx, input bit both,
                           input int exp_code, input int exp_ncmd, input int mid_start);
        int cyc;
        lock_after   = lk;
        to_idx       = tidx;
        to_with_done = both;
        n_cmd  = 0;
        n_read = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        check("R2", "busy after start", int'(busy_o), 1);
        check("R2", "clk_en after start", int'(clk_en_o), 1);
        check("R2", "code cleared on start", int'(err_code_o), 0);
        while (!done_o && cyc < 2000) begin
            if (cyc <= S && cmd_valid_o) check("R2", "command during settle", 1, 0);
            if (cyc == S + 1) check("R2", "first command after settle", int'(cmd_valid_o), 1);
            if (cyc == mid_start) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
        end
        check(req, "end cycle", cyc, exp_cycles(exp_ncmd));
        check(req, "result code", int'(err_code_o), exp_code);
        check("R9", "err flag", int'(err_o), int'(exp_code != 0));
        check(req, "clk_en at end", int'(clk_en_o), int'(exp_code == 0));
        check("R9", "busy low with done", int'(busy_o), 0);
        check(req, "command count", n_cmd, exp_ncmd);
        for (int i = 0; i < n_cmd && i < 64; i++) begin
            if (i == 0) begin
                check("R3", "cmd0 op", int'(log_op[i]), 0);
                check("R3", "cmd0 data", int'(log_dat[i]), 16'h7F3F);
            end else if (i == 1) begin
                check("R3", "cmd1 op", int'(log_op[i]), 1);
                check("R3", "cmd1 data", int'(log_dat[i]), 16'h0001);
            end else if (i % 2 == 0) begin
                check("R4", "poll addr op", int'(log_op[i]), 0);
                check("R4", "poll addr data", int'(log_dat[i]), 16'h2003);
            end else begin
                check("R4", "poll read op", int'(log_op[i]), 2);
                check("R4", "poll read data", int'(log_dat[i]), 0);
            end
        end
        repeat (4) @(negedge clk);
        check("R9", "done is a pulse", int'(done_o), 0);
        check("R9", "code held after done", int'(err_code_o), exp_code);
        check(req, "no command after end", n_cmd, exp_ncmd);
        check(req, "valid low after end", int'(cmd_valid_o), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "busy", int'(busy_o), 0);
        check("R1", "done", int'(done_o), 0);
        check("R1", "err", int'(err_o), 0);
        check("R1", "code", int'(err_code_o), 0);
        check("R1", "clk_en", int'(clk_en_o), 0);
        check("R1", "valid", int'(cmd_valid_o), 0);
    endtask

    task automatic t_lock_first();   run_seq("R5", 0, -1, 1'b0, 0, 4, -1);   endtask
    task automatic t_lock_middle();  run_seq("R5", 2, -1, 1'b0, 0, 8, -1);   endtask
    task automatic t_lock_last();    run_seq("R5", MAXT - 1, -1, 1'b0, 0, 2 + 2 * MAXT, -1); endtask
    task automatic t_lock_never();   run_seq("R6", NEVER, -1, 1'b0, 2, 2 + 2 * MAXT, -1); endtask
    task automatic t_to_first();     run_seq("R7", NEVER, 0, 1'b0, 1, 1, -1); endtask
    task automatic t_to_read();      run_seq("R7", NEVER, 5, 1'b0, 1, 6, -1); endtask
    task automatic t_to_with_done(); run_seq("R7", 0, 1, 1'b1, 1, 2, -1);    endtask
    task automatic t_start_busy();   run_seq("R10", 0, -1, 1'b0, 0, 4, S + 3); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_lock_first();
        t_lock_never();
        t_lock_middle();
        t_lock_last();
        t_to_first();
        t_to_read();
        t_to_with_done();
        t_start_busy();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule